// File: doc/BRIEF.md
# Burst power-loop switch sequencer

This block is the digital sequencer behind a burst-mode transmit power control loop. Five analog switches (offset sampling, pre-set bias, clamp, integrator drive and loop feedback) are opened and closed in a fixed order. The order starts when the supply is applied and reset is released at the start of each burst. The analog amplifiers, integrator, comparators and DAC sit outside the block. Two comparator flags stand in for them: one reports that the DAC ramp has begun, and the other reports that the control output has dropped below the home-position level.

The sequencer has five named states, which run in a fixed order:

1. SETTLE (code 0): the detector offsets are sampled. It ends when the settle timer expires (transition *settle-done*).
2. PREBIAS (code 1): the control output is held at the pre-bias level. It waits for the latched ramp-start event (transition *ramp-seen*).
3. HOMERISE (code 2): the control output rises to the home level for a fixed interval (transition *home-done*).
4. LOOP (code 3): the loop is closed. It waits for the below-home flag (transition *burst-end*).
5. ENDHOLD (code 4): the pre-bias pattern is restored and held until the next reset.

The settle interval and the home-rise interval are counted in clock cycles. Both counts are derived from a clock-frequency parameter. The defaults are 45 µs and 2 µs.

Top module: `burst_loop_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, phase_o is 0 and the switch enables {sample, preset, clamp, integ, feedback} read 1,1,1,0,0. A value of 1 means the switch is closed.
- R2: The SETTLE state (code 0) lasts exactly SETTLE_CYC clock cycles after reset release. At that point the block moves to PREBIAS (code 1) with the pattern 0,1,1,0,0.
- R3: The ramp-start flag is ignored in SETTLE, including on the edge that leaves SETTLE. A flag held high throughout SETTLE and dropped afterwards leaves the block in PREBIAS.
- R4: In PREBIAS, a ramp-start pulse of a single cycle is latched. The block enters HOMERISE (code 2) with the pattern 0,1,0,1,0 on the clock edge after the edge that sampled the pulse.
- R5: HOMERISE lasts exactly HOME_CYC cycles, however long PREBIAS lasted. It then enters LOOP (code 3) with the pattern 0,0,0,1,1.
- R6: The below-home flag has no effect in SETTLE, PREBIAS and HOMERISE.
- R7: In LOOP, the block stays in LOOP while below-home is low. A below-home flag sampled high moves the block to ENDHOLD (code 4) with the pattern 1,1,1,0,0 on that same edge.
- R8: ENDHOLD keeps its code and pattern whatever the inputs do, until reset. Reset then starts a new burst in SETTLE.
- R9: The switch enables and phase_o are registered and change on the same edge. Every cycle shows exactly the pattern that belongs to the reported phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, asserted until the supply is up at the start of each burst |
| ramp_start_i | input | 1 | Comparator flag: the DAC ramp has started |
| below_home_i | input | 1 | Comparator flag: the control output is below the home level |
| sw_sample_o | output | 1 | Offset-sampling switch enable |
| sw_preset_o | output | 1 | Pre-set bias switch enable |
| sw_clamp_o | output | 1 | Pre-bias clamp switch enable |
| sw_integ_o | output | 1 | Integrator drive switch enable |
| sw_feedback_o | output | 1 | Loop feedback switch enable |
| phase_o | output | 3 | Current state code (0 to 4) |

## Verification
The bench builds the block with CLK_KHZ set to 1000. With that value the settle interval becomes 45 cycles and the home-rise interval becomes 2 cycles, which keeps every burst short. The bench can therefore sweep the PREBIAS wait over 0 to 5 extra cycles and the LOOP wait over 0 to 3 cycles. Each of these combinations runs with and without both flags held high through the early states. Exact phase boundaries are computed arithmetically from the two counts. A per-cycle monitor compares each pattern against its phase code.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [2:0] {
        PH_SETTLE   = 3'd0,
        PH_PREBIAS  = 3'd1,
        PH_HOMERISE = 3'd2,
        PH_LOOP     = 3'd3,
        PH_ENDHOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic sample;
        logic preset;
        logic clamp;
        logic integ;
        logic feedback;
    } sw_t;

    localparam sw_t SW_PREBIAS_PAT = '{sample: 1'b1, preset: 1'b1, clamp: 1'b1, integ: 1'b0, feedback: 1'b0};

    function automatic sw_t pattern_of(phase_e p);
        sw_t s;
        case (p)
            PH_SETTLE:   s = SW_PREBIAS_PAT;
            PH_PREBIAS:  s = '{sample: 1'b0, preset: 1'b1, clamp: 1'b1, integ: 1'b0, feedback: 1'b0};
            PH_HOMERISE: s = '{sample: 1'b0, preset: 1'b1, clamp: 1'b0, integ: 1'b1, feedback: 1'b0};
            PH_LOOP:     s = '{sample: 1'b0, preset: 1'b0, clamp: 1'b0, integ: 1'b1, feedback: 1'b1};
            PH_ENDHOLD:  s = SW_PREBIAS_PAT;
            default:     s = SW_PREBIAS_PAT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bls_interval_timer.sv
module bls_interval_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'((LIMIT < 1) ? 0 : LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign done = run && (cnt_q == LAST);

    // R2 / R5: a running interval never counts past its last cycle
    a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST));

    // R2 / R5: an idle timer restarts from zero
    a_r2_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/bls_event_latch.sv
module bls_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic evt,
    output logic hit
);
    logic hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (arm && evt) begin
            hit_q <= 1'b1;
        end
    end

    assign hit = hit_q;

    // R3: an event that arrives while disarmed is not captured
    a_r3_no_unarmed_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !hit_q) |=> !hit_q);

    // R4: once captured, the event stays captured for the burst
    a_r4_capture_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |=> hit_q);

endmodule

// File: rtl/bls_switch_reg.sv
module bls_switch_reg
    import bls_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e next_phase,
    output sw_t    sw_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= SW_PREBIAS_PAT;
        end else begin
            sw_q <= pattern_of(next_phase);
        end
    end

    // R9: the clamp and the integrator drive are never closed together
    a_r9_clamp_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_q.clamp && sw_q.integ));

    // R9: offset sampling and loop feedback are never closed together
    a_r9_sample_feedback_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q.sample |-> !sw_q.feedback);

endmodule

// File: rtl/burst_loop_sequencer.sv
module burst_loop_sequencer
    import bls_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int SETTLE_NS = 45000,
    parameter int HOME_NS   = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ramp_start_i,
    input  logic       below_home_i,
    output logic       sw_sample_o,
    output logic       sw_preset_o,
    output logic       sw_clamp_o,
    output logic       sw_integ_o,
    output logic       sw_feedback_o,
    output logic [2:0] phase_o
);
    localparam longint SETTLE_RAW = (longint'(CLK_KHZ) * longint'(SETTLE_NS)) / 64'sd1000000;
    localparam longint HOME_RAW   = (longint'(CLK_KHZ) * longint'(HOME_NS)) / 64'sd1000000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
    localparam int HOME_CYC   = (HOME_RAW < 1) ? 1 : int'(HOME_RAW);

    phase_e state_q;
    phase_e state_d;
    sw_t    sw_q;
    logic   settle_done;
    logic   home_done;
    logic   ramp_hit;

    bls_interval_timer #(.LIMIT(SETTLE_CYC)) u_settle_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == PH_SETTLE),
        .done  (settle_done)
    );

    bls_interval_timer #(.LIMIT(HOME_CYC)) u_home_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == PH_HOMERISE),
        .done  (home_done)
    );

    bls_event_latch u_ramp_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (state_q == PH_PREBIAS),
        .evt   (ramp_start_i),
        .hit   (ramp_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SETTLE:   if (settle_done)  state_d = PH_PREBIAS;   // settle-done
            PH_PREBIAS:  if (ramp_hit)     state_d = PH_HOMERISE;  // ramp-seen
            PH_HOMERISE: if (home_done)    state_d = PH_LOOP;      // home-done
            PH_LOOP:     if (below_home_i) state_d = PH_ENDHOLD;   // burst-end
            PH_ENDHOLD:                    state_d = PH_ENDHOLD;
            default:                       state_d = PH_ENDHOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: the switch register loads from the same next state
    bls_switch_reg u_switches (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_phase (state_d),
        .sw_q       (sw_q)
    );

    assign sw_sample_o   = sw_q.sample;
    assign sw_preset_o   = sw_q.preset;
    assign sw_clamp_o    = sw_q.clamp;
    assign sw_integ_o    = sw_q.integ;
    assign sw_feedback_o = sw_q.feedback;
    assign phase_o       = state_q;

    // R2: SETTLE can only stay or move to PREBIAS
    a_r2_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETTLE) |=> (state_q == PH_SETTLE || state_q == PH_PREBIAS));

    // R4: PREBIAS holds until the ramp event is latched
    a_r4_wait_for_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_PREBIAS && !ramp_hit) |=> (state_q == PH_PREBIAS));

    // R6: no early jump to ENDHOLD
    a_r6_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETTLE || state_q == PH_PREBIAS || state_q == PH_HOMERISE)
        |=> (state_q != PH_ENDHOLD));

    // R7: below-home in LOOP ends the burst
    a_r7_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOOP && below_home_i) |=> (state_q == PH_ENDHOLD));

    // R8: ENDHOLD is held with a steady pattern
    a_r8_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ENDHOLD) |=> (state_q == PH_ENDHOLD && $stable(sw_q)));

    // R9: the switch register always matches the reported phase
    a_r9_pattern_matches: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q == pattern_of(state_q));

endmodule

// File: tb/burst_loop_sequencer_bench.sv
`timescale 1ns/1ps
module burst_loop_sequencer_bench;

    localparam int KHZ = 1000;
    localparam int SC  = (KHZ * 45000) / 1000000;
    localparam int HC  = (KHZ * 2000) / 1000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ramp = 1'b0;
    logic       below = 1'b0;
    logic       s1, s2, s3, s4, s5;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    int mon_err = 0;
    int mon_cnt = 0;

    always #4 clk = ~clk;

    burst_loop_sequencer #(.CLK_KHZ(KHZ)) u_burst_loop_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .ramp_start_i  (ramp),
        .below_home_i  (below),
        .sw_sample_o   (s1),
        .sw_preset_o   (s2),
        .sw_clamp_o    (s3),
        .sw_integ_o    (s4),
        .sw_feedback_o (s5),
        .phase_o       (phase)
    );

    function automatic logic [4:0] expect_sw(input logic [2:0] p);
        case (p)
            3'd1:    return 5'b01100;
            3'd2:    return 5'b01010;
            3'd3:    return 5'b00011;
            default: return 5'b11100;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string req, input logic [2:0] p);
        logic [4:0] sw;
        sw = {s1, s2, s3, s4, s5};
        chk(phase == p, req, int'(phase), int'(p));
        chk(sw == expect_sw(p), req, int'(sw), int'(expect_sw(p)));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R9: every cycle out of reset shows the pattern of its phase
    always @(negedge clk) begin
        if (rst_n) begin
            mon_cnt++;
            if (phase > 3'd4 || {s1, s2, s3, s4, s5} != expect_sw(phase)) mon_err++;
        end
    end

    task automatic burst(input int rw, input int bw, input logic early);
        rst_n = 1'b0; ramp = 1'b0; below = 1'b0;
        repeat (3) step();
        chk_state("R1", 3'd0);
        rst_n = 1'b1;
        ramp = early; below = early;
        step();
        chk_state("R1", 3'd0);
        repeat (SC - 2) step();
        chk_state("R2", 3'd0);
        step();
        chk_state("R2", 3'd1);
        ramp = 1'b0;
        repeat (rw + 2) step();
        chk_state(early ? "R3" : "R4", 3'd1);
        ramp = 1'b1;
        step();
        ramp = 1'b0;
        chk_state("R4", 3'd1);
        step();
        chk_state("R4", 3'd2);
        repeat (HC - 1) step();
        chk_state(early ? "R6" : "R5", 3'd2);
        step();
        chk_state("R5", 3'd3);
        below = 1'b0;
        repeat (bw) step();
        chk_state("R7", 3'd3);
        below = 1'b1;
        step();
        chk_state("R7", 3'd4);
        below = 1'b0; ramp = 1'b1;
        repeat (3) step();
        ramp = 1'b0; below = 1'b1;
        step();
        chk_state("R8", 3'd4);
        below = 1'b0;
    endtask

    initial begin
        for (int e = 0; e < 2; e++)
            for (int rw = 0; rw < 6; rw++)
                for (int bw = 0; bw < 4; bw++)
                    burst(rw, bw, logic'(e));
        chk(mon_err == 0 && mon_cnt > 0, "R9", mon_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule